// File: doc/BRIEF.md
# DDR Memory Initialization Sequencer

This block is a hardware state machine that wakes an attached DDR1 or DDR2 SDRAM after reset. It does so without any processor help. A pulse on `start` latches two strap inputs. The first strap picks the DDR2 or DDR1 command script. The second strap says whether the reference clock is 40 MHz or 25 MHz.

The sequencer then walks the chosen script. Each step raises a one-cycle command strobe together with a one-hot command code and a 16-bit mode/address value. A parameterized number of idle cycles follows every strobe. When the script is finished, the block loads three things: the refresh-interval word, which depends on the clock strap, and the two data-strobe capture taps. It then raises `done` and keeps it high until reset.

On the DDR2 path the block also presents a DDR2-enable configuration word for the rest of the controller. The physical pins, the data path and real JEDEC wait times belong to other blocks.

Top module: `ddr_init_seq`

## Requirements
- R1: `cmd_code` is one-hot whenever `cmd_valid` is high and zero otherwise. Each bit names one command: bit 0 mode-register load, bit 1 extended-mode load, bit 2 auto-refresh, bit 3 precharge-all, bit 4 extended-mode-2 load, bit 5 extended-mode-3 load.
- R2: With `strap_ddr2`=1 the strobes come in this order, eleven in all, with `cmd_arg` as shown:
  - precharge-all
  - ext-mode-2 0x000
  - ext-mode-3 0x000
  - ext-mode 0x000
  - mode 0x100
  - precharge-all
  - auto-refresh
  - auto-refresh
  - mode 0xA33
  - ext-mode 0x382
  - ext-mode 0x402
- R3: With `strap_ddr2`=0 the strobes come in this order, five in all: precharge-all, mode 0x133, ext-mode 0x002, precharge-all, mode 0x033. `cmd_arg` is 0 for precharge-all and auto-refresh.
- R4: Each strobe lasts exactly one cycle. The first strobe appears in the cycle after the edge that accepts `start`. Consecutive strobes are GAP_CYCLES+1 cycles apart.
- R5: `refresh_word` has bit 14 set and the interval in bits 9:0. The interval is 624 when `strap_ref40`=1 and 390 otherwise. All other bits are zero.
- R6: At completion, `tap_word` holds 0x08 in lane 0 (bits 7:0) and 0x09 in lane 1 (bits 15:8).
- R7: `ddr2_cfg` becomes 0x0A59 in the cycle after `start` is accepted on the DDR2 path. That value has enable at bit 0, tFAW=22 in bits 7:2, ODT at bit 9 and write latency 2 in bits 13:10. It stays 0 on the DDR1 path.
- R8: `done` rises exactly GAP_CYCLES+2 cycles after the last strobe. This is the same cycle the refresh and tap values appear. `done` then stays high until reset.
- R9: The straps are sampled only when `start` is accepted. A `start` pulse while a sequence runs, or while `done` is high, produces no strobe and changes no output.
- R10: While `rst_n` is low, and right after it is released, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence from idle |
| strap_ddr2 | input | 1 | 1 selects the DDR2 script |
| strap_ref40 | input | 1 | 1 selects the 40 MHz refresh interval |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 6 | One-hot command code |
| cmd_arg | output | 16 | Mode/extended-mode value for the command |
| refresh_word | output | 16 | Refresh enable and interval |
| tap_word | output | 16 | Two capture-tap lanes, lane 0 low |
| ddr2_cfg | output | 16 | DDR2 enable/latency configuration word |
| done | output | 1 | Sequence complete, sticky |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Step order and mode words.** Both scripts run under every strap combination, and each strobe's position is compared with its expected code and value. A swapped OCD default/exit pair, or a DLL-reset word reused where the normal word belongs, shows up at the exact step.
- **Strobe spacing and `done` timing.** These are measured in cycles. An off-by-one in the idle-gap counter shifts every later strobe, and a `done` raised a cycle early or late is reported.
- **Strap and start noise.** Straps and `start` are toggled at random during a run and after completion. A design that re-samples straps would change its script or its refresh interval, and a design that re-arms on `start` would emit a second sequence.
- **Reset in mid-sequence.** A reset partway through must return all outputs to zero.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef enum logic [5:0] {
      CMD_NONE = 6'h00,
      CMD_MRS  = 6'h01,
      CMD_EMR  = 6'h02,
      CMD_AREF = 6'h04,
      CMD_PREA = 6'h08,
      CMD_EMR2 = 6'h10,
      CMD_EMR3 = 6'h20
   } cmd_e;

   typedef struct packed {
      cmd_e        code;
      logic [15:0] arg;
   } step_t;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ISSUE = 3'd1,
      ST_GAP   = 3'd2,
      ST_LOAD  = 3'd3,
      ST_FIN   = 3'd4
   } seq_state_e;

   localparam int unsigned STEPS_DDR2 = 11;
   localparam int unsigned STEPS_DDR1 = 5;
   localparam int unsigned IDX_W      = 4;

   function automatic step_t ddr2_step(input logic [IDX_W-1:0] i);
      step_t s;
      s.arg = 16'h0000;
      unique case (i)
         4'd0:    s.code = CMD_PREA;
         4'd1:    s.code = CMD_EMR2;
         4'd2:    s.code = CMD_EMR3;
         4'd3:    s.code = CMD_EMR;
         4'd4:    begin s.code = CMD_MRS; s.arg = 16'h0100; end
         4'd5:    s.code = CMD_PREA;
         4'd6:    s.code = CMD_AREF;
         4'd7:    s.code = CMD_AREF;
         4'd8:    begin s.code = CMD_MRS; s.arg = 16'h0A33; end
         4'd9:    begin s.code = CMD_EMR; s.arg = 16'h0382; end
         4'd10:   begin s.code = CMD_EMR; s.arg = 16'h0402; end
         default: s.code = CMD_NONE;
      endcase
      return s;
   endfunction

   function automatic step_t ddr1_step(input logic [IDX_W-1:0] i);
      step_t s;
      s.arg = 16'h0000;
      unique case (i)
         4'd0:    s.code = CMD_PREA;
         4'd1:    begin s.code = CMD_MRS; s.arg = 16'h0133; end
         4'd2:    begin s.code = CMD_EMR; s.arg = 16'h0002; end
         4'd3:    s.code = CMD_PREA;
         4'd4:    begin s.code = CMD_MRS; s.arg = 16'h0033; end
         default: s.code = CMD_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/ddr_init_script.sv
module ddr_init_script
   import ddr_init_pkg::*;
#(
   parameter int unsigned ARG_W = 16
) (
   input  logic                 sel_ddr2,
   input  logic [IDX_W-1:0]     idx,
   output cmd_e                 code,
   output logic [ARG_W-1:0]     arg,
   output logic                 is_last
);
   localparam logic [IDX_W-1:0] LAST2 = IDX_W'(STEPS_DDR2 - 1);
   localparam logic [IDX_W-1:0] LAST1 = IDX_W'(STEPS_DDR1 - 1);

   if (ARG_W < 12 || ARG_W > 16) begin : g_bad_arg_w
      $error("ddr_init_script: ARG_W must lie in 12..16");
   end

   step_t st;

   always_comb begin
      st      = sel_ddr2 ? ddr2_step(idx) : ddr1_step(idx);
      code    = st.code;
      arg     = st.arg[ARG_W-1:0];
      is_last = sel_ddr2 ? (idx == LAST2) : (idx == LAST1);
   end
endmodule

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
   parameter int unsigned GAP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int unsigned CW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
   localparam logic [CW-1:0] LIMIT = CW'(GAP_CYCLES - 1);

   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("ddr_init_gap_timer: GAP_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign last = run && (cnt == LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n || !run || last) cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   assert_gap_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= LIMIT));
endmodule

// File: rtl/ddr_init_cfg_regs.sv
module ddr_init_cfg_regs #(
   parameter int unsigned REF_W      = 16,
   parameter int unsigned INTV_W     = 10,
   parameter int unsigned REF_EN_BIT = 14,
   parameter int unsigned INTV_25    = 390,
   parameter int unsigned INTV_40    = 624,
   parameter int unsigned TAP_W      = 8,
   parameter int unsigned NUM_TAPS   = 2,
   parameter int unsigned TAP_BASE   = 8,
   parameter int unsigned CFG_W      = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_ddr2,
   input  logic                      load_final,
   input  logic                      ref40,
   output logic [REF_W-1:0]          refresh_word,
   output logic [NUM_TAPS*TAP_W-1:0] tap_word,
   output logic [CFG_W-1:0]          ddr2_cfg
);
   localparam logic [CFG_W-1:0] DDR2_CFG_VAL =
      CFG_W'((32'd2 << 10) | (32'd1 << 9) | (32'd22 << 2) | 32'd1);

   if (REF_EN_BIT >= REF_W || INTV_W > REF_EN_BIT) begin : g_bad_ref
      $error("ddr_init_cfg_regs: refresh field layout does not fit");
   end
   if (INTV_40 >= (1 << INTV_W) || INTV_25 >= (1 << INTV_W)) begin : g_bad_intv
      $error("ddr_init_cfg_regs: interval exceeds field");
   end
   if (CFG_W < 14) begin : g_bad_cfg
      $error("ddr_init_cfg_regs: CFG_W must be at least 14");
   end

   logic [REF_W-1:0] ref_next;
   always_comb begin
      ref_next = '0;
      ref_next[REF_EN_BIT] = 1'b1;
      ref_next[INTV_W-1:0] = ref40 ? INTV_W'(INTV_40) : INTV_W'(INTV_25);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          refresh_word <= '0;
      else if (load_final) refresh_word <= ref_next;
   end

   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      always_ff @(posedge clk) begin
         if (!rst_n)          tap_word[g*TAP_W +: TAP_W] <= '0;
         else if (load_final) tap_word[g*TAP_W +: TAP_W] <= TAP_W'(TAP_BASE + g);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         ddr2_cfg <= '0;
      else if (load_ddr2) ddr2_cfg <= DDR2_CFG_VAL;
   end

   assert_cfg_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_ddr2 |=> (ddr2_cfg == DDR2_CFG_VAL));
   assert_refresh_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_final |=> refresh_word[REF_EN_BIT]);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int unsigned GAP_CYCLES = 4,
   parameter int unsigned ARG_W      = 16,
   parameter int unsigned TAP_W      = 8,
   parameter int unsigned INTV_25    = 390,
   parameter int unsigned INTV_40    = 624
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               strap_ddr2,
   input  logic               strap_ref40,
   output logic               cmd_valid,
   output logic [5:0]         cmd_code,
   output logic [ARG_W-1:0]   cmd_arg,
   output logic [15:0]        refresh_word,
   output logic [2*TAP_W-1:0] tap_word,
   output logic [15:0]        ddr2_cfg,
   output logic               done
);
   seq_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             sel_ddr2;
   logic             sel_ref40;
   cmd_e             step_code;
   logic [ARG_W-1:0] step_arg;
   logic             step_last;
   logic             gap_last;
   logic             accept;

   assign accept = (state == ST_IDLE) && start;

   ddr_init_script #(.ARG_W(ARG_W)) u_script (
      .sel_ddr2 (sel_ddr2),
      .idx      (idx),
      .code     (step_code),
      .arg      (step_arg),
      .is_last  (step_last)
   );

   ddr_init_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_GAP),
      .last  (gap_last)
   );

   ddr_init_cfg_regs #(
      .INTV_25 (INTV_25),
      .INTV_40 (INTV_40),
      .TAP_W   (TAP_W)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_ddr2    (accept && strap_ddr2),
      .load_final   (state == ST_LOAD),
      .ref40        (sel_ref40),
      .refresh_word (refresh_word),
      .tap_word     (tap_word),
      .ddr2_cfg     (ddr2_cfg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         sel_ddr2  <= 1'b0;
         sel_ref40 <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state     <= ST_ISSUE;
               idx       <= '0;
               sel_ddr2  <= strap_ddr2;
               sel_ref40 <= strap_ref40;
            end
            ST_ISSUE: state <= ST_GAP;
            ST_GAP: if (gap_last) begin
               if (step_last) state <= ST_LOAD;
               else begin
                  state <= ST_ISSUE;
                  idx   <= idx + 1'b1;
               end
            end
            ST_LOAD: state <= ST_FIN;
            ST_FIN:  state <= ST_FIN;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_valid = (state == ST_ISSUE);
      cmd_code  = cmd_valid ? step_code : 6'h00;
      cmd_arg   = cmd_valid ? step_arg  : '0;
      done      = (state == ST_FIN);
   end

   assert_code_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $onehot(cmd_code));
   assert_code_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (cmd_code == 6'h00));
   assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);
   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   assert_done_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tap_word[TAP_W-1:0] == TAP_W'(8)) && refresh_word[14]);
   assert_no_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid);
   assert_straps_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) && $past(state != ST_IDLE) |-> $stable(sel_ddr2) && $stable(sel_ref40));
endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
   localparam int GAP = 3;
   localparam int SPACE = GAP + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        strap_ddr2 = 1'b0;
   logic        strap_ref40 = 1'b0;
   logic        cmd_valid;
   logic [5:0]  cmd_code;
   logic [15:0] cmd_arg;
   logic [15:0] refresh_word;
   logic [15:0] tap_word;
   logic [15:0] ddr2_cfg;
   logic        done;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   ddr_init_seq #(.GAP_CYCLES(GAP)) u_dut (
      .clk, .rst_n, .start, .strap_ddr2, .strap_ref40,
      .cmd_valid, .cmd_code, .cmd_arg, .refresh_word, .tap_word,
      .ddr2_cfg, .done
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // expected script: {code, arg}
   function automatic logic [21:0] exp_step(input bit d2, input int n);
      if (d2) begin
         case (n)
            0: return {6'h08, 16'h000};  1: return {6'h10, 16'h000};
            2: return {6'h20, 16'h000};  3: return {6'h02, 16'h000};
            4: return {6'h01, 16'h100};  5: return {6'h08, 16'h000};
            6: return {6'h04, 16'h000};  7: return {6'h04, 16'h000};
            8: return {6'h01, 16'hA33};  9: return {6'h02, 16'h382};
            default: return {6'h02, 16'h402};
         endcase
      end
      case (n)
         0: return {6'h08, 16'h000};  1: return {6'h01, 16'h133};
         2: return {6'h02, 16'h002};  3: return {6'h08, 16'h000};
         default: return {6'h01, 16'h033};
      endcase
   endfunction

   function automatic logic [15:0] exp_refresh(input bit r40);
      return 16'h4000 | (r40 ? 16'd624 : 16'd390);
   endfunction

   task automatic check_zero(input string tag);
      check(!cmd_valid && cmd_code == 0 && cmd_arg == 0 && !done, {tag, " R10 cmd/done"},
            {cmd_valid, done, cmd_code, cmd_arg}, 0);
      check(refresh_word == 0 && tap_word == 0 && ddr2_cfg == 0, {tag, " R10 regs"},
            {refresh_word, tap_word}, 0);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; start = 1'b0;
      @(negedge clk); check_zero("in reset");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); check_zero("after reset");
   endtask

   task automatic run_seq(input bit d2, input bit r40, input bit noisy);
      int n = 0;
      int cyc = 0;
      int nexp = d2 ? 11 : 5;
      int done_at = (nexp - 1) * SPACE + GAP + 2;
      bit seen_done = 0;
      @(negedge clk); strap_ddr2 = d2; strap_ref40 = r40; start = 1'b1;
      @(negedge clk); start = noisy ? 1'($urandom) : 1'b0;
      check(ddr2_cfg == (d2 ? 16'h0A59 : 16'h0), "R7 cfg word", ddr2_cfg, d2 ? 16'h0A59 : 16'h0);
      while (!seen_done && cyc < 400) begin
         if (cmd_valid) begin
            logic [21:0] e = exp_step(d2, n);
            check(n < nexp, d2 ? "R2 extra strobe" : "R3 extra strobe", n, nexp);
            check({cmd_code, cmd_arg} == e, d2 ? "R2 step" : "R3 step", {cmd_code, cmd_arg}, e);
            check(cyc == n * SPACE, "R4 strobe timing", cyc, n * SPACE);
            check($onehot(cmd_code), "R1 onehot", cmd_code, 0);
            n++;
         end else begin
            if (cmd_code != 0) check(0, "R1 idle code", cmd_code, 0);
         end
         if (done) begin
            seen_done = 1;
            check(cyc == done_at, "R8 done cycle", cyc, done_at);
            check(refresh_word == exp_refresh(r40), "R5 refresh", refresh_word, exp_refresh(r40));
            check(tap_word == 16'h0908, "R6 taps", tap_word, 16'h0908);
         end else if (noisy) begin
            strap_ddr2 = 1'($urandom); strap_ref40 = 1'($urandom); start = 1'($urandom);
         end
         if (!seen_done) begin @(negedge clk); cyc++; end
      end
      check(seen_done, "R8 done reached", cyc, done_at);
      check(n == nexp, d2 ? "R2 count" : "R3 count", n, nexp);
      check(ddr2_cfg == (d2 ? 16'h0A59 : 16'h0), "R7 cfg held", ddr2_cfg, d2 ? 16'h0A59 : 16'h0);
      // start after completion must be ignored
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         start = 1'($urandom); strap_ddr2 = 1'($urandom); strap_ref40 = 1'($urandom);
         if (cmd_valid || !done || refresh_word != exp_refresh(r40))
            check(0, "R9 rearm/R8 sticky", {cmd_valid, done, refresh_word}, {2'b01, exp_refresh(r40)});
      end
      checks++;
      start = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd7121));
      do_reset();
      run_seq(1, 1, 0); do_reset();
      run_seq(1, 0, 0); do_reset();
      run_seq(0, 1, 0); do_reset();
      run_seq(0, 0, 0); do_reset();
      for (int r = 0; r < 6; r++) begin
         run_seq(1'($urandom), 1'($urandom), 1); do_reset();
      end
      // reset in mid-sequence
      @(negedge clk); strap_ddr2 = 1; start = 1;
      @(negedge clk); start = 0;
      repeat (13) @(negedge clk);
      do_reset();
      run_seq(0, 1, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule